// File: doc/BRIEF.md
# Serial Word Memory Slave with Busy Polling

This block is the slave end of a three-wire serial memory link of the chip-select, clock and data-in / data-out kind. It contains a behavioural array of 16-bit words, 256 of them by default. A bus master raises chip select and clocks in a frame with the most significant bit first. The frame is a start bit, a two-bit opcode, an eight-bit address and, for writes, one or more 16-bit data words. The block then either streams array words back on data out, or stores the words and runs a modelled self-timed programming cycle. The length of that cycle is a parameter counted in system clocks.

Everything runs on a fast system clock, and the three bus inputs pass through two-flop synchronisers. A serial clock rising edge is recognised when the synchronised clock goes from 0 to 1. Data out comes with an enable, and the pad drives the line only while that enable is high. During a programming cycle the master may raise chip select and poll data out, which reads 0 while busy and 1 once ready.

The controller is a single state machine. Its states are IDLE (waiting for a start bit), OPCODE, ADDR, READ (streaming), WDATA (collecting data words), WEND (the frame is complete and chip select must fall next), DRAIN (the frame is void, waiting for chip select to fall), COMMIT (words are written into the array, one per clock) and BUSY (the programming timer runs). The transitions are:
- IDLE→OPCODE on a start bit.
- OPCODE→ADDR after two bits.
- ADDR→READ, WDATA or DRAIN on address decode.
- WDATA→WEND on the last word.
- WDATA→COMMIT on chip select falling at a page-word boundary.
- WEND→COMMIT on chip select falling.
- WEND→DRAIN on an extra clock edge.
- COMMIT→BUSY after the last word.
- BUSY→IDLE when the timer expires.
- Any shifting state→IDLE on chip select falling.

Top module: `mw_mem_slave`

## Requirements
- R1: After reset the data-out enable is low, writes are disabled and no programming cycle runs.
- R2: While chip select is high, 0 bits before the first sampled 1 are skipped. That 1 is the start bit. It is followed by a 2-bit opcode and an 8-bit address, both MSB first, sampled on serial clock rising edges.
- R3: Opcode 10 is a read. After the last address bit, data out shows a dummy 0. Each later rising edge presents the next bit of the addressed 16-bit word, MSB first.
- R4: While chip select stays high, a read continues with the following words and no dummy bit between them. The address wraps from the highest word to word 0.
- R5: Opcode 01 writes one word: 8 address bits, then 16 data bits. The word is stored when chip select falls after exactly 16 data edges.
- R6: A write frame ended with too few data edges, or with an extra edge after its last data bit, stores nothing and starts no cycle.
- R7: Opcode 11 is a page write of 1 to 4 words. Chip select falls at a word boundary. Word k goes to the address whose bits 1:0 equal the start address's bits 1:0 plus k, modulo 4, with the upper bits unchanged.
- R8: During a programming cycle, data out is enabled whenever chip select is high and reads 0. The cycle lasts at least WRITE_CYCLES system clocks from the fall of chip select.
- R9: When the cycle ends, data out reads 1 while chip select is high. It stays so until chip select falls or a new start bit is taken.
- R10: Serial clock edges and data during a programming cycle are ignored. An instruction clocked in while busy has no effect.
- R11: Opcode 00 uses address bits 7:6 as a sub-code: 11 enables writes, 00 disables them, 01 is write-all. With writes disabled, write frames store nothing and start no cycle. Reads work either way.
- R12: Write-all (opcode 00, sub-code 01) plus one data word stores that word in every array location.
- R13: With chip select low, the data-out enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Output enable for the data-out pad; low means high impedance |

## Verification
A serial clock rising edge reaches data out three system clocks after the pin changes: two synchroniser flops and the state register. The bench drives every serial clock phase for four system clocks and samples data out at the end of the high phase. That sample point is one clock after the earliest time the data is due and well before the next edge. A programming cycle ends about 3 + words + WRITE_CYCLES system clocks after chip select falls. The bench polls data out each clock and checks that the busy time lies between WRITE_CYCLES and that bound plus a margin. Array contents are compared word by word against a bench model, which updates only when a requirement says a write takes effect.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_READ,
        ST_WDATA,
        ST_WEND,
        ST_DRAIN,
        ST_COMMIT,
        ST_BUSY
    } mw_state_e;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_PAGE  = 2'b11
    } mw_op_e;

    typedef enum logic [1:0] {
        SUB_WDIS = 2'b00,
        SUB_WALL = 2'b01,
        SUB_RSVD = 2'b10,
        SUB_WEN  = 2'b11
    } mw_sub_e;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else         chain_q <= {chain_q[STAGES-2:0], d_i[i]};
        end
        assign q_o[i] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) cells[waddr_i] <= wdata_i;
        rdata_o <= cells[raddr_i];
    end
endmodule

// File: rtl/mw_write_timer.sv
module mw_write_timer #(
    parameter int CYCLES = 500
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] left_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            left_q <= '0;
            busy_o <= 1'b0;
        end else if (start_i) begin
            left_q <= TW'(CYCLES - 1);
            busy_o <= 1'b1;
        end else if (busy_o) begin
            if (left_q == '0) busy_o <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end
    end

    assign done_o = busy_o && (left_q == '0);

    // R8: the timer releases busy the cycle after it signals done
    p_done_clears_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> !busy_o);
endmodule

// File: rtl/mw_mem_slave.sv
module mw_mem_slave
    import mw_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int ADDR_USED    = 8,
    parameter int DATA_W       = 16,
    parameter int PAGE_WORDS   = 4,
    parameter int WRITE_CYCLES = 500
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_i,
    input  logic sck_i,
    input  logic sdi_i,
    output logic sdo_o,
    output logic sdo_oe_o
);
    localparam int ARR_AW    = ADDR_USED;
    localparam int ARR_DEPTH = 1 << ARR_AW;
    localparam int PW        = $clog2(PAGE_WORDS);
    localparam int BIT_W     = $clog2(DATA_W);
    localparam int CNT_W     = BIT_W + 1;

    // ---------------- input synchronisation and edge detect ----------------
    logic [2:0] sync_q;
    logic       cs_s, sck_s, sdi_s;
    logic       cs_q, sck_q;
    logic       sck_rise, cs_fall;

    mw_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   ({cs_i, sck_i, sdi_i}),
        .q_o   (sync_q)
    );

    assign {cs_s, sck_s, sdi_s} = sync_q;
    assign sck_rise = sck_s && !sck_q;
    assign cs_fall  = cs_q && !cs_s;

    // ---------------- state and datapath registers ----------------
    mw_state_e              state_q, state_d;
    logic [1:0]             op_q;
    logic [CNT_W-1:0]       bit_cnt_q;
    logic [ADDR_W-2:0]      addr_sr_q;
    logic [DATA_W-2:0]      word_sr_q;
    logic [DATA_W-1:0]      page_buf_q [PAGE_WORDS];
    logic [PW:0]            words_q;
    logic [ARR_AW-1:0]      base_q;
    logic [ARR_AW-1:0]      rd_addr_q;
    logic [ARR_AW-1:0]      commit_idx_q;
    logic                   wr_en_q;
    logic                   rdy_flag_q;
    logic                   sdo_q;

    // ---------------- decoded helpers ----------------
    logic [ADDR_W-1:0]      addr_full;
    logic [DATA_W-1:0]      word_full;
    logic [1:0]             sub_code;
    logic                   opc_last, addr_last, word_last;
    logic                   start_seen;
    logic                   page_full;
    logic                   page_boundary;
    logic                   commit_all;
    logic                   commit_last;
    logic [PW:0]            words_m1;

    assign addr_full     = {addr_sr_q, sdi_s};
    assign word_full     = {word_sr_q, sdi_s};
    assign sub_code      = addr_full[ADDR_W-1 -: 2];
    assign opc_last      = (bit_cnt_q == CNT_W'(1));
    assign addr_last     = (bit_cnt_q == CNT_W'(ADDR_W - 1));
    assign word_last     = (bit_cnt_q == CNT_W'(DATA_W - 1));
    assign start_seen    = (state_q == ST_IDLE) && cs_s && sck_rise && sdi_s;
    assign page_full     = (words_q == (PW+1)'(PAGE_WORDS - 1));
    assign page_boundary = (op_q == OP_PAGE) && (bit_cnt_q == '0) && (words_q != '0);
    assign commit_all    = (op_q == OP_EXT);
    assign words_m1      = words_q - 1'b1;
    assign commit_last   = commit_all ? (commit_idx_q == ARR_AW'(ARR_DEPTH - 1))
                                      : (commit_idx_q == ARR_AW'(words_m1));

    // ---------------- array and timer ----------------
    logic                   arr_we;
    logic [ARR_AW-1:0]      arr_waddr;
    logic [DATA_W-1:0]      arr_wdata;
    logic [DATA_W-1:0]      arr_rdata;
    logic [PW-1:0]          page_lo;
    logic                   tmr_start, tmr_busy, tmr_done;

    assign page_lo   = base_q[PW-1:0] + commit_idx_q[PW-1:0];
    assign arr_we    = (state_q == ST_COMMIT);
    assign arr_waddr = commit_all ? commit_idx_q : {base_q[ARR_AW-1:PW], page_lo};
    assign arr_wdata = commit_all ? page_buf_q[0] : page_buf_q[commit_idx_q[PW-1:0]];
    assign tmr_start = (state_q == ST_COMMIT) && commit_last;

    mw_word_array #(.AW(ARR_AW), .DW(DATA_W)) u_array (
        .clk_i  (clk_i),
        .we_i   (arr_we),
        .waddr_i(arr_waddr),
        .wdata_i(arr_wdata),
        .raddr_i(rd_addr_q),
        .rdata_o(arr_rdata)
    );

    mw_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(tmr_start),
        .busy_o (tmr_busy),
        .done_o (tmr_done)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_seen) state_d = ST_OPCODE;
            end
            ST_OPCODE: begin
                if (!cs_s)                      state_d = ST_IDLE;
                else if (sck_rise && opc_last)  state_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (!cs_s) state_d = ST_IDLE;
                else if (sck_rise && addr_last) begin
                    unique case (mw_op_e'(op_q))
                        OP_READ:  state_d = ST_READ;
                        OP_WRITE,
                        OP_PAGE:  state_d = ST_WDATA;
                        OP_EXT:   state_d = (sub_code == SUB_WALL) ? ST_WDATA : ST_DRAIN;
                        default:  state_d = ST_DRAIN;
                    endcase
                end
            end
            ST_READ: begin
                if (!cs_s) state_d = ST_IDLE;
            end
            ST_WDATA: begin
                if (!cs_s)
                    state_d = (page_boundary && wr_en_q) ? ST_COMMIT : ST_IDLE;
                else if (sck_rise && word_last)
                    state_d = ((op_q == OP_PAGE) && !page_full) ? ST_WDATA : ST_WEND;
            end
            ST_WEND: begin
                if (!cs_s)         state_d = wr_en_q ? ST_COMMIT : ST_IDLE;
                else if (sck_rise) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!cs_s) state_d = ST_IDLE;
            end
            ST_COMMIT: begin
                if (commit_last) state_d = ST_BUSY;
            end
            ST_BUSY: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- datapath / output registers ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cs_q         <= 1'b0;
            sck_q        <= 1'b0;
            op_q         <= '0;
            bit_cnt_q    <= '0;
            addr_sr_q    <= '0;
            word_sr_q    <= '0;
            words_q      <= '0;
            base_q       <= '0;
            rd_addr_q    <= '0;
            commit_idx_q <= '0;
            wr_en_q      <= 1'b0;
            rdy_flag_q   <= 1'b0;
            sdo_q        <= 1'b0;
            for (int i = 0; i < PAGE_WORDS; i++) page_buf_q[i] <= '0;
        end else begin
            cs_q  <= cs_s;
            sck_q <= sck_s;

            if (state_q == ST_BUSY && tmr_done) rdy_flag_q <= 1'b1;
            else if (cs_fall || start_seen)     rdy_flag_q <= 1'b0;

            unique case (state_q)
                ST_IDLE: begin
                    bit_cnt_q <= '0;
                    if (start_seen) op_q <= '0;
                end
                ST_OPCODE: if (sck_rise) begin
                    op_q      <= {op_q[0], sdi_s};
                    bit_cnt_q <= opc_last ? '0 : bit_cnt_q + 1'b1;
                end
                ST_ADDR: if (sck_rise) begin
                    addr_sr_q <= addr_full[ADDR_W-2:0];
                    bit_cnt_q <= addr_last ? '0 : bit_cnt_q + 1'b1;
                    if (addr_last) begin
                        base_q    <= addr_full[ARR_AW-1:0];
                        rd_addr_q <= addr_full[ARR_AW-1:0];
                        words_q   <= '0;
                        sdo_q     <= 1'b0;
                        if (op_q == OP_EXT && sub_code == SUB_WEN)  wr_en_q <= 1'b1;
                        if (op_q == OP_EXT && sub_code == SUB_WDIS) wr_en_q <= 1'b0;
                    end
                end
                ST_READ: if (sck_rise) begin
                    sdo_q <= arr_rdata[BIT_W'(DATA_W - 1) - bit_cnt_q[BIT_W-1:0]];
                    if (word_last) begin
                        bit_cnt_q <= '0;
                        rd_addr_q <= rd_addr_q + 1'b1;
                    end else begin
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                end
                ST_WDATA: if (sck_rise) begin
                    word_sr_q <= word_full[DATA_W-2:0];
                    if (word_last) begin
                        bit_cnt_q                    <= '0;
                        page_buf_q[words_q[PW-1:0]]  <= word_full;
                        words_q                      <= words_q + 1'b1;
                    end else begin
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                end
                ST_WEND, ST_DRAIN: begin
                    commit_idx_q <= '0;
                end
                ST_COMMIT: begin
                    commit_idx_q <= commit_idx_q + 1'b1;
                end
                ST_BUSY: begin
                    commit_idx_q <= '0;
                end
                default: ;
            endcase

            if (state_q == ST_WDATA && !cs_s) commit_idx_q <= '0;
        end
    end

    // ---------------- output decode ----------------
    always_comb begin
        sdo_oe_o = 1'b0;
        sdo_o    = 1'b0;
        if (cs_s) begin
            unique case (state_q)
                ST_READ:            begin sdo_oe_o = 1'b1; sdo_o = sdo_q; end
                ST_COMMIT, ST_BUSY: begin sdo_oe_o = 1'b1; sdo_o = 1'b0;  end
                ST_IDLE:            begin sdo_oe_o = rdy_flag_q; sdo_o = rdy_flag_q; end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    // R11: the array is only written while writes are enabled
    p_write_needs_enable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arr_we |-> wr_en_q);

    // R7: a page commit never changes the upper address bits between words
    p_page_upper_fixed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arr_we && !commit_all && $past(arr_we))
            |-> (arr_waddr[ARR_AW-1:PW] == $past(arr_waddr[ARR_AW-1:PW])));

    // R10: bus edges during a programming cycle leave the write-enable state alone
    p_busy_ignores_bus_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_BUSY && sck_rise) |=> $stable(wr_en_q));

    // R3: the first bit presented by a read is a 0
    p_dummy_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_READ && $past(state_q) == ST_ADDR) |-> !sdo_q);

    // R4: the streaming read address wraps to zero after the top word
    p_rollover_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_READ && $past(state_q) == ST_READ
         && $past(rd_addr_q) == ARR_AW'(ARR_DEPTH - 1) && rd_addr_q != $past(rd_addr_q))
            |-> (rd_addr_q == '0));

    // R8: while the timer runs the controller is busy
    p_timer_in_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmr_busy |-> (state_q == ST_BUSY));
endmodule

// File: tb/mw_mem_slave_tb.sv
module mw_mem_slave_tb_top;
    localparam int WRITE_CYCLES = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe;

    int   n_run = 0, n_fail = 0;
    int   cyc = 0;
    int   t0 = 0;
    bit   done = 1'b0;
    logic [15:0] ref_mem [256];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mw_mem_slave #(.WRITE_CYCLES(WRITE_CYCLES)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sck_i(sck), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit b);
        sdi = b; tick(4); sck = 1'b1; tick(4); sck = 1'b0;
    endtask

    task automatic send(input int v, input int n);
        for (int i = n - 1; i >= 0; i--) pulse(v[i]);
    endtask

    task automatic sel();
        cs = 1'b1; tick(4);
    endtask

    task automatic desel();
        t0 = cyc; cs = 1'b0; tick(6);
    endtask

    task automatic hdr(input int op, input int a);
        send(1, 1); send(op, 2); send(a, 8);
    endtask

    task automatic finish_write(input int nw, input bit prog, input string req);
        tick(2); cs = 1'b1; tick(4);
        if (prog) begin
            int n = 0;
            chk(sdo_oe && !sdo, "R8 busy shown", {sdo_oe, sdo}, 2'b10);
            while (!(sdo_oe && sdo) && n < 5000) begin tick(1); n++; end
            chk(sdo_oe && sdo, "R9 ready shown", {sdo_oe, sdo}, 2'b11);
            chk((cyc - t0) >= WRITE_CYCLES && (cyc - t0) <= WRITE_CYCLES + nw + 30,
                "R8 cycle length", cyc - t0, WRITE_CYCLES + nw);
        end else begin
            chk(!sdo_oe, {req, " no cycle started"}, sdo_oe, 0);
        end
        cs = 1'b0; tick(6);
        chk(!sdo_oe, "R13 released when deselected", sdo_oe, 0);
    endtask

    task automatic cmd_ext(input int a);
        sel(); hdr(0, a); desel();
    endtask

    task automatic wr_word(input int a, input logic [15:0] d, input int nbits,
                           input int extra, input bit prog, input string req);
        sel(); hdr(1, a);
        for (int i = 15; i >= 16 - nbits; i--) pulse(d[i]);
        for (int i = 0; i < extra; i++) pulse(1'b0);
        desel();
        if (prog) ref_mem[a & 255] = d;
        finish_write(1, prog, req);
    endtask

    task automatic rd_stream(input int a, input int n, input int zeros, input string req);
        sel();
        send(0, zeros);
        hdr(2, a);
        chk(sdo_oe && !sdo, "R3 dummy zero", {sdo_oe, sdo}, 2'b10);
        for (int w = 0; w < n; w++) begin
            logic [15:0] v = '0;
            for (int b = 0; b < 16; b++) begin
                pulse(1'b0);
                v = {v[14:0], sdo};
            end
            chk(v == ref_mem[(a + w) & 255], req, v, ref_mem[(a + w) & 255]);
        end
        desel();
    endtask

    task automatic page_wr(input int a, input int nw, input int seed);
        sel(); hdr(3, a);
        for (int k = 0; k < nw; k++) begin
            logic [15:0] d = 16'(seed + k * 16'h0101);
            send(d, 16);
            ref_mem[(a & 8'hFC) | ((a + k) & 3)] = d;
        end
        desel();
        finish_write(nw, 1'b1, "R7");
    endtask

    initial begin
        tick(3);
        chk(!sdo_oe, "R1 output released at reset", sdo_oe, 0);
        rst_n = 1'b1;
        tick(4);
        // R1: writes disabled out of reset
        wr_word(8'h05, 16'h1234, 16, 0, 1'b0, "R1 write before enable");

        // R11 enable, R12 write-all
        cmd_ext(8'hC0);
        sel(); hdr(0, 8'h40); send(16'hA5C3, 16); desel();
        for (int i = 0; i < 256; i++) ref_mem[i] = 16'hA5C3;
        finish_write(256, 1'b1, "R12");
        rd_stream(8'h00, 3, 0, "R12 write-all content");
        rd_stream(8'hFF, 1, 0, "R12 write-all top word");

        // R11 disable: no write, reads still work
        cmd_ext(8'h00);
        wr_word(8'h10, 16'hBEEF, 16, 0, 1'b0, "R11 write while disabled");
        rd_stream(8'h10, 1, 0, "R11 read unaffected by disable");
        cmd_ext(8'hFF);

        // R5 sweep of single writes
        for (int i = 0; i < 16; i++)
            wr_word((i * 17 + 3) & 255, 16'((i * 16'h1111) ^ 16'h0F0F), 16, 0, 1'b1, "R5");

        // R6 aborted frames
        wr_word(8'h33, 16'h5555, 10, 0, 1'b0, "R6 short frame");
        wr_word(8'h34, 16'h6666, 16, 1, 1'b0, "R6 long frame");
        sel(); hdr(3, 8'h50); send(16'h7777, 16); send(0, 4); desel();
        finish_write(1, 1'b0, "R6 page cut mid-word");

        // R7 page writes, every start offset, full and partial
        for (int lo = 0; lo < 4; lo++) begin
            page_wr(8'h80 | lo, 4, 16'h7000 + lo * 16);
            rd_stream(8'h80, 4, 0, "R7 full page wrap");
        end
        page_wr(8'h91, 2, 16'h2200);
        page_wr(8'h97, 3, 16'h3300);
        rd_stream(8'h90, 8, 0, "R7 partial page");

        // R10 bus ignored while busy, R9 ready until start bit
        sel(); hdr(1, 8'h44); send(16'hC0DE, 16); desel();
        ref_mem[8'h44] = 16'hC0DE;
        tick(2); cs = 1'b1; tick(4);
        chk(sdo_oe && !sdo, "R8 busy before bus noise", {sdo_oe, sdo}, 2'b10);
        hdr(0, 8'h00);
        begin
            int n = 0;
            while (!(sdo_oe && sdo) && n < 5000) begin tick(1); n++; end
        end
        chk(sdo_oe && sdo, "R9 ready held with select high", {sdo_oe, sdo}, 2'b11);
        tick(20);
        chk(sdo_oe && sdo, "R9 ready still held", {sdo_oe, sdo}, 2'b11);
        pulse(1'b1);
        chk(!sdo_oe, "R9 ready cleared by start bit", sdo_oe, 0);
        cs = 1'b0; tick(6);
        wr_word(8'h45, 16'hFACE, 16, 0, 1'b1, "R10 enable survived busy");

        // R2 leading zeros before the start bit
        rd_stream(8'h44, 2, 3, "R2 leading zeros skipped");

        // R4 streaming over the whole array with rollover
        rd_stream(8'hFE, 260, 0, "R4 stream with rollover");

        done = 1'b1;
    end

    initial begin
        wait (done || cyc > 190000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d expected done", cyc);
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule